// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a 16-bit timer. An external counter supplies its count value, its counting mode (stopped, up to a period, continuous, or up/down), a strobe that fires when the count is zero, and a strobe that fires when the count equals the period value. The channel holds a 16-bit control word, a data word and a compare latch that sits behind the data word.

In capture mode the channel watches one of four input sources for the selected edge and stores the count in the data word. The edge can be taken straight from the input, or after a two-flop resynchronizer that delays it by two clocks. A capture that arrives while the previous one is still pending raises an overflow flag. In compare mode the channel flags the cycle in which the count matches the latch. It drives a PWM pin through eight output modes that combine that match event with the period event. The data word moves into the latch either at once or on a chosen counter event. An interrupt request is raised while the flag and its enable are both set.

Top module: `cc_channel`

## Requirements
- R1: After reset every writable control bit, the data word, the compare latch, `pwm_out` and `irq` are 0.
- R2: Control bits 13:12 choose the capture source (00 `in_a`, 01 `in_b`, 10 constant 0, 11 constant 1). Control bit 3 always reads the level of the chosen source. Switching the source from constant 0 to constant 1 counts as a rising edge.
- R3: With bit 8 = 1 (capture) and bit 11 = 0, an edge that matches bits 15:14 (00 none, 01 rising, 10 falling, 11 both) is seen at the clock edge where it is first sampled. At that edge `tmr_cnt` is copied into the data word and flag bit 0 is set.
- R4: With bit 11 = 1, the same capture happens two clocks later than with bit 11 = 0, and it stores the count present at that later edge.
- R5: A capture that occurs while flag bit 0 is already 1 sets overflow bit 1.
- R6: Bits 0 and 1 stay set until a control write stores 0 into them. A hardware set in the same cycle as such a write wins over the write.
- R7: In compare mode (bit 8 = 0), the match event is active in each cycle where `tmr_cnt` equals the latch and `tmr_mode` is not 00 (stop). That cycle sets flag bit 0.
- R8: With bits 10:9 = 00, a data write updates the latch at the same edge as the data word.
- R9: With bits 10:9 = 01, the latch takes the data word when `cnt_zero` is high. With 10, it also does so in up/down mode (`tmr_mode` = 11) when `cnt_period` is high.
- R10: With bits 10:9 = 11, the latch takes the data word on the match event.
- R11: Bits 7:5 select the output mode. 1 sets on match; 2 toggles on match and clears on period; 3 sets on match and clears on period; 4 toggles on match; 5 clears on match; 6 toggles on match and sets on period; 7 clears on match and sets on period. When both events occur in the same cycle, the period action wins.
- R12: In output mode 0, `pwm_out` follows control bit 2 combinationally.
- R13: `irq` is high exactly when control bit 4 and flag bit 0 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_cnt | input | W | Counter value |
| tmr_mode | input | 2 | Counter mode: 00 stop, 01 up, 10 continuous, 11 up/down |
| cnt_zero | input | 1 | High while the counter is at zero |
| cnt_period | input | 1 | High while the counter equals the period value |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write value |
| dat_we | input | 1 | Data word write strobe |
| dat_wdata | input | W | Data word write value |
| in_a | input | 1 | Capture source A |
| in_b | input | 1 | Capture source B |
| ctl_q | output | 16 | Control word readback with live input level in bit 3 |
| dat_q | output | W | Data word (captured or written) |
| cmp_latch | output | W | Compare latch |
| pwm_out | output | 1 | Channel output |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a match event and a period event in the same cycle while the output is already in a known state. That is the only situation where the period-wins rule of R11 is visible. The stimulus first runs output mode 7 with the latch equal to the period value, so the pin is left high. It then switches to mode 3 and waits for the counter to reach the period. Resynchronized capture is probed by letting the input settle for several clocks, then checking both the cycle where the raw path would already have fired and the cycle where the delayed path does fire. The forced edge is produced by writing the source field from constant 0 to constant 1.

// File: rtl/cc_channel.sv
module cc_channel #(
  parameter int W = 16
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tmr_cnt,
  input  logic [1:0]   tmr_mode,
  input  logic         cnt_zero,
  input  logic         cnt_period,
  input  logic         ctl_we,
  input  logic [15:0]  ctl_wdata,
  input  logic         dat_we,
  input  logic [W-1:0] dat_wdata,
  input  logic         in_a,
  input  logic         in_b,
  output logic [15:0]  ctl_q,
  output logic [W-1:0] dat_q,
  output logic [W-1:0] cmp_latch,
  output logic         pwm_out,
  output logic         irq
);
  localparam logic [1:0] MODE_STOP = 2'b00;
  localparam logic [1:0] MODE_UPDN = 2'b11;

  logic [15:4] hi;
  logic [2:0]  lo;
  logic        cci, a_prev, s1, s2, s3, cur, prv, cap_ev, equn, ld_ev, out_r, out_nx;
  logic        unused_wbit;

  logic [1:0] edge_sel, src_sel, load_sel;
  logic [2:0] omode;
  logic       sync_en, cap_mode;

  assign edge_sel    = hi[15:14];
  assign src_sel     = hi[13:12];
  assign sync_en     = hi[11];
  assign load_sel    = hi[10:9];
  assign cap_mode    = hi[8];
  assign omode       = hi[7:5];
  assign unused_wbit = ctl_wdata[3];

  always_comb begin
    case (src_sel)
      2'b00:   cci = in_a;
      2'b01:   cci = in_b;
      2'b10:   cci = 1'b0;
      default: cci = 1'b1;
    endcase
  end

  assign cur    = sync_en ? s2 : cci;
  assign prv    = sync_en ? s3 : a_prev;
  assign cap_ev = cap_mode & ((edge_sel[0] & cur & ~prv) | (edge_sel[1] & ~cur & prv));
  assign equn   = ~cap_mode & (tmr_mode != MODE_STOP) & (tmr_cnt == cmp_latch);

  always_comb begin
    case (load_sel)
      2'b00:   ld_ev = dat_we;
      2'b01:   ld_ev = cnt_zero;
      2'b10:   ld_ev = cnt_zero | ((tmr_mode == MODE_UPDN) & cnt_period);
      default: ld_ev = equn;
    endcase
  end

  always_comb begin
    out_nx = out_r;
    case (omode)
      3'd0: out_nx = lo[2];
      3'd1: if (equn) out_nx = 1'b1;
      3'd2: begin
        if (equn) out_nx = ~out_r;
        if (cnt_period) out_nx = 1'b0;
      end
      3'd3: begin
        if (equn) out_nx = 1'b1;
        if (cnt_period) out_nx = 1'b0;
      end
      3'd4: if (equn) out_nx = ~out_r;
      3'd5: if (equn) out_nx = 1'b0;
      3'd6: begin
        if (equn) out_nx = ~out_r;
        if (cnt_period) out_nx = 1'b1;
      end
      default: begin
        if (equn) out_nx = 1'b0;
        if (cnt_period) out_nx = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi        <= '0;
      lo        <= '0;
      dat_q     <= '0;
      cmp_latch <= '0;
      out_r     <= 1'b0;
      a_prev    <= 1'b0;
      s1        <= 1'b0;
      s2        <= 1'b0;
      s3        <= 1'b0;
    end else begin
      if (ctl_we) hi <= ctl_wdata[15:4];
      lo <= (ctl_we ? ctl_wdata[2:0] : lo) | {1'b0, cap_ev & lo[0], cap_ev | equn};
      if (cap_ev)      dat_q <= tmr_cnt;
      else if (dat_we) dat_q <= dat_wdata;
      if (ld_ev) cmp_latch <= (load_sel == 2'b00) ? dat_wdata : dat_q;
      out_r  <= out_nx;
      a_prev <= cci;
      s1     <= cci;
      s2     <= s1;
      s3     <= s2;
    end
  end

  assign ctl_q   = {hi, cci, lo};
  assign pwm_out = (omode == 3'd0) ? lo[2] : out_r;
  assign irq     = hi[4] & lo[0];
endmodule

// File: rtl/cc_channel_chk.sv
module cc_channel_chk #(
  parameter int W = 16
)(
  input logic         clk,
  input logic         rst_n,
  input logic         ctl_we,
  input logic         dat_we,
  input logic         cnt_zero,
  input logic [15:0]  ctl_q,
  input logic [W-1:0] dat_q,
  input logic [W-1:0] cmp_latch,
  input logic         pwm_out,
  input logic         irq
);
  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_q[0]) && !$past(ctl_we) |-> ctl_q[0]);

  // R5
  cov_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[1]) && !$past(ctl_we) |-> $past(ctl_q[0]));

  // R3
  cap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dat_q) && !$past(dat_we) |-> ctl_q[0]);

  // R11
  set_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_q[7:5]) == 3'd1 && ctl_q[7:5] == 3'd1 |-> !$fell(pwm_out));

  // R11
  reset_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_q[7:5]) == 3'd5 && ctl_q[7:5] == 3'd5 |-> !$rose(pwm_out));

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_q[10:9]) == 2'b01 && !$past(cnt_zero) |-> $stable(cmp_latch));

  // R13
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctl_q[0] && ctl_q[4]);
endmodule

bind cc_channel cc_channel_chk #(.W(W)) u_chk (.*);

// File: tb/sim_cc_channel.sv
module sim_cc_channel;
  localparam int CLK_PERIOD = 10;
  localparam int PER = 40;

  logic        clk = 0, rst_n = 0;
  logic [15:0] tmr_cnt = 0;
  logic [1:0]  tmr_mode = 0;
  logic        cnt_zero, cnt_period;
  logic        ctl_we = 0, dat_we = 0, in_a = 0, in_b = 0;
  logic [15:0] ctl_wdata = 0, dat_wdata = 0;
  logic [15:0] ctl_q, dat_q, cmp_latch;
  logic        pwm_out, irq;

  int errors = 0, checks = 0;
  bit up = 1;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign cnt_zero   = (tmr_mode != 0) && (tmr_cnt == 0);
  assign cnt_period = (tmr_mode != 0) && (tmr_cnt == PER);

  cc_channel #(.W(16)) u0 (.*);

  logic [15:0] m_ctl, m_dat, m_lat;
  bit m_out;
  bit hist[$] = '{0, 0, 0, 0};

  function automatic bit lvl(logic [1:0] s);
    return (s == 0) ? in_a : (s == 1) ? in_b : (s == 3);
  endfunction

  always @(posedge clk) begin : model
    bit lv, cur, prv, capev, eq;
    logic [15:0] nctl, ndat, nlat;
    bit nout;
    if (!rst_n) begin
      m_ctl = 0; m_dat = 0; m_lat = 0; m_out = 0; hist = '{0, 0, 0, 0};
    end else begin
      lv = lvl(m_ctl[13:12]);
      hist.push_front(lv);
      hist = hist[0:3];
      cur = m_ctl[11] ? hist[2] : hist[0];
      prv = m_ctl[11] ? hist[3] : hist[1];
      capev = m_ctl[8] && ((m_ctl[14] && cur && !prv) || (m_ctl[15] && !cur && prv));
      eq = !m_ctl[8] && tmr_mode != 0 && tmr_cnt == m_lat;
      nctl = ctl_we ? (ctl_wdata & 16'hFFF7) : m_ctl;
      if (capev || eq) nctl[0] = 1;
      if (capev && m_ctl[0]) nctl[1] = 1;
      ndat = capev ? tmr_cnt : dat_we ? dat_wdata : m_dat;
      nlat = m_lat;
      case (m_ctl[10:9])
        0: if (dat_we) nlat = dat_wdata;
        1: if (cnt_zero) nlat = m_dat;
        2: if (cnt_zero || (tmr_mode == 3 && cnt_period)) nlat = m_dat;
        default: if (eq) nlat = m_dat;
      endcase
      nout = m_out;
      case (m_ctl[7:5])
        0: nout = m_ctl[2];
        1: nout = eq ? 1'b1 : m_out;
        2: nout = cnt_period ? 1'b0 : eq ? !m_out : m_out;
        3: nout = cnt_period ? 1'b0 : eq ? 1'b1 : m_out;
        4: nout = eq ? !m_out : m_out;
        5: nout = eq ? 1'b0 : m_out;
        6: nout = cnt_period ? 1'b1 : eq ? !m_out : m_out;
        default: nout = cnt_period ? 1'b1 : eq ? 1'b0 : m_out;
      endcase
      m_ctl = nctl; m_dat = ndat; m_lat = nlat; m_out = nout;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (rst_n) begin
      chk("R2 ctl_q", ctl_q, {m_ctl[15:4], lvl(m_ctl[13:12]), m_ctl[2:0]});
      chk("R3 dat_q", dat_q, m_dat);
      chk("R8 cmp_latch", cmp_latch, m_lat);
      chk("R11 pwm_out", pwm_out, (m_ctl[7:5] == 0) ? m_ctl[2] : m_out);
      chk("R13 irq", irq, m_ctl[4] & m_ctl[0]);
    end
    case (tmr_mode)
      1: tmr_cnt = (tmr_cnt >= PER) ? 0 : tmr_cnt + 1;
      2: tmr_cnt = tmr_cnt + 1;
      3: if (up) begin
           if (tmr_cnt >= PER) begin up = 0; tmr_cnt = tmr_cnt - 1; end
           else tmr_cnt = tmr_cnt + 1;
         end else begin
           if (tmr_cnt == 0) begin up = 1; tmr_cnt = tmr_cnt + 1; end
           else tmr_cnt = tmr_cnt - 1;
         end
      default: ;
    endcase
  endtask

  task automatic wctl(logic [15:0] v);
    ctl_we = 1; ctl_wdata = v; tick(); ctl_we = 0;
  endtask

  task automatic wdat(logic [15:0] v);
    dat_we = 1; dat_wdata = v; tick(); dat_we = 0;
  endtask

  task automatic wait_cnt(logic [15:0] v);
    for (int i = 0; i < 500 && tmr_cnt != v; i++) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] c;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1
    chk("R1 ctl", ctl_q, 16'h0000);
    chk("R1 dat", dat_q, 0);
    chk("R1 latch", cmp_latch, 0);
    chk("R1 pwm", pwm_out, 0);
    chk("R1 irq", irq, 0);

    // R2 source select and readback
    wctl(16'h3000);
    chk("R2 const1", ctl_q[3], 1);
    in_b = 1;
    wctl(16'h1000);
    chk("R2 in_b", ctl_q[3], 1);
    wctl(16'h2000);
    chk("R2 const0", ctl_q[3], 0);

    // R12
    wctl(16'h0004);
    chk("R12 out bit", pwm_out, 1);

    // R3 asynchronous rising capture
    tmr_mode = 2; tmr_cnt = 16'h0100;
    wctl(16'h4100);
    tick();
    c = tmr_cnt; in_a = 1;
    tick();
    chk("R3 cap value", dat_q, c);
    chk("R3 flag", ctl_q[0], 1);

    // R4 synchronized falling capture
    repeat (4) tick();
    wctl(16'h8900);
    repeat (4) tick();
    c = tmr_cnt; in_a = 0;
    tick();
    chk("R4 not yet", ctl_q[0], 0);
    tick();
    chk("R4 still not", ctl_q[0], 0);
    tick();
    chk("R4 delayed value", dat_q, c + 2);
    chk("R4 flag", ctl_q[0], 1);

    // R5 overflow on second capture
    repeat (4) tick();
    wctl(16'hC100);
    tick();
    in_a = 1; tick();
    chk("R5 first cap no cov", ctl_q[1:0], 2'b01);
    in_a = 0; tick();
    chk("R5 cov set", ctl_q[1:0], 2'b11);

    // R6 clear by write, hold otherwise
    wctl(16'hC100);
    chk("R6 cleared", ctl_q[1:0], 2'b00);
    repeat (3) tick();
    chk("R6 stays clear", ctl_q[1:0], 2'b00);

    // R2 forced edge by source switch
    wctl(16'h6100);
    tick();
    c = tmr_cnt;
    wctl(16'h7100);
    chk("R2 forced no cap yet", ctl_q[0], 0);
    tick();
    chk("R2 forced cap", ctl_q[0], 1);
    chk("R2 forced value", dat_q, c + 1);

    // R7 and R8 compare
    tmr_cnt = 50;
    wdat(100);
    chk("R8 immediate load", cmp_latch, 100);
    wctl(16'h0000);
    wait_cnt(100);
    tick();
    chk("R7 match flag", ctl_q[0], 1);
    wctl(16'h0000);
    tmr_mode = 0; tmr_cnt = 100;
    repeat (3) tick();
    chk("R7 stopped no match", ctl_q[0], 0);

    // R9 load at zero (up mode), then at period in up/down
    tmr_mode = 1; tmr_cnt = 5;
    wctl(16'h0200);
    wdat(30);
    chk("R9 held", cmp_latch, 100);
    wait_cnt(0);
    tick();
    chk("R9 zero load", cmp_latch, 30);
    tmr_mode = 3; up = 1; tmr_cnt = 5;
    wctl(16'h0400);
    wdat(15);
    chk("R9 held updn", cmp_latch, 30);
    wait_cnt(PER);
    tick();
    chk("R9 period load", cmp_latch, 15);

    // R10 load on match
    wctl(16'h0600);
    wdat(7);
    chk("R10 held", cmp_latch, 15);
    wait_cnt(15);
    tick();
    chk("R10 match load", cmp_latch, 7);

    // R11 all output modes in up mode
    tmr_mode = 1; tmr_cnt = 0;
    wctl(16'h0000);
    wdat(10);
    for (int m = 1; m < 8; m++) begin
      wctl(16'(m << 5));
      repeat (90) tick();
    end
    wait_cnt(12);
    tick();
    chk("R11 mode7 cleared", pwm_out, 0);
    wait_cnt(2);
    tick();
    chk("R11 mode7 set", pwm_out, 1);
    wctl(16'h00E0);
    wdat(PER);
    wait_cnt(5);
    tick();
    chk("R11 coincident set", pwm_out, 1);
    wctl(16'h0060);
    wait_cnt(PER);
    tick();
    chk("R11 period wins", pwm_out, 0);

    // R13 interrupt
    wctl(16'h0011);
    chk("R13 irq on", irq, 1);
    wctl(16'h0010);
    chk("R13 irq off", irq, 0);

    repeat (5) tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule